// File: doc/BRIEF.md
# Accumulator Machine Datapath

An 8-bit accumulator-style datapath whose every transfer is steered by a separate controller through explicit control inputs. It holds an accumulator that shifts in place, a memory data register, a count register that decrements in place, a saved-return register, an instruction pointer that steps by one or two in place, and a one-bit zero flag. All other arithmetic and logic goes through one shared four-function ALU. Each register with more than one source has its own selector.

Memory is outside the block. It is reached through an address output, which carries either the instruction pointer or the memory data register, and an 8-bit read data input. The controller loads the accumulator from an external input port, and the accumulator drives the output port. The low nibble of the byte on the read data input is brought out separately, for use as an exception code or as a register index. Decoding, sequencing and microcode belong to the controller and are not part of this block.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears every register, including the zero flag, to 0. After reset `out_port`, `zero_o` and `mem_addr` (for both address selections) all read 0.
- R2: The ALU takes the accumulator as operand A. For operand B it takes the memory data register when `alu_bsel`=0, or `mem_rdata` when `alu_bsel`=1. `alu_op` selects the function: 0 add, 1 subtract (A−B), 2 bitwise AND, 3 bitwise OR. Results wrap modulo 256.
- R3: With `acc_ld`=0, `acc_shr` alone shifts the accumulator right by one and fills bit 7 with 0. `acc_shl` alone shifts it left by one and fills bit 0 with 0. Both together, or neither, hold its value.
- R4: A load enable takes priority over the in-place operation requested in the same cycle. This applies to the accumulator shift, the count decrement, the pointer step, and the flag clear and preset.
- R5: When `acc_ld`=1, `acc_sel` picks the accumulator source: 0 `in_port`, 1 ALU result, 2 `mem_rdata`, 3 count register. The memory data register and the count register load from `mem_rdata` when their select is 0, or from the accumulator when it is 1.
- R6: `cnt_dec` without `cnt_ld` decrements the count register by one, so 0x00 wraps to 0xFF.
- R7: `ip_inc` without `ip_ld` advances the instruction pointer by 1, or by 2 when `ip_by2`=1, modulo 256.
- R8: `sr_ld` stores the instruction pointer plus 2 into the saved-return register. `ip_ld` loads the pointer from `mem_rdata` when `ip_sel`=0, or from the saved-return register when `ip_sel`=1.
- R9: `z_ld` loads the zero flag with 1 when the current ALU result is 0, and with 0 otherwise. Without `z_ld`, `z_clr` clears the flag. Without either, `z_set` presets it. `zero_o` shows the flag.
- R10: `mem_addr` shows the instruction pointer when `addr_sel`=0 and the memory data register when `addr_sel`=1. `fetch_nib` equals `mem_rdata[3:0]` at all times.
- R11: `out_port` always shows the accumulator register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | W | External input port |
| out_port | output | W | Accumulator value |
| mem_addr | output | W | Memory address (pointer or data register) |
| mem_rdata | input | W | Memory read data |
| fetch_nib | output | 4 | Low nibble of read data |
| zero_o | output | 1 | Zero flag |
| alu_op | input | 2 | ALU function select |
| alu_bsel | input | 1 | ALU operand B select |
| acc_ld | input | 1 | Accumulator load enable |
| acc_sel | input | 2 | Accumulator source select |
| acc_shr | input | 1 | Accumulator shift right |
| acc_shl | input | 1 | Accumulator shift left |
| md_ld | input | 1 | Memory data register load |
| md_sel | input | 1 | Memory data register source |
| cnt_ld | input | 1 | Count register load |
| cnt_sel | input | 1 | Count register source |
| cnt_dec | input | 1 | Count decrement |
| sr_ld | input | 1 | Saved-return load (pointer + 2) |
| ip_ld | input | 1 | Instruction pointer load |
| ip_sel | input | 1 | Instruction pointer source |
| ip_inc | input | 1 | Instruction pointer step enable |
| ip_by2 | input | 1 | Step by two instead of one |
| z_ld | input | 1 | Load flag from ALU zero test |
| z_clr | input | 1 | Clear flag |
| z_set | input | 1 | Preset flag |
| addr_sel | input | 1 | Address source select |

## Verification
The bench drives shifts of values with bit 0 and bit 7 set, so a design that rotates instead of filling with zero shows a stray bit at the other end. It also asserts both shift controls together, where a wrong design would favour one direction. It steps the count register from 0x00 and the pointer by two from 0xFE, to catch wrap errors. It requests a load and an in-place operation in the same cycle on each counting register and on the flag, which exposes a design whose priority is inverted. It runs a subtraction that yields zero and then an operation that does not, and it recovers the count and saved-return values through the accumulator and the pointer. A swapped operand or source select then appears as a wrong value on the port.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_t;

  typedef enum logic [1:0] {
    ACC_FROM_IN  = 2'd0,
    ACC_FROM_ALU = 2'd1,
    ACC_FROM_MEM = 2'd2,
    ACC_FROM_CNT = 2'd3
  } acc_src_t;
endpackage

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/dp_acc.sv
module dp_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         shr,
  input  logic         shl,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (ld)            q <= d;
    else if (shr && !shl)   q <= {1'b0, q[W-1:1]};
    else if (shl && !shr)   q <= {q[W-2:0], 1'b0};
  end

  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && shr && shl) |=> q == $past(q));
  assert_shr_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && shr && !shl) |=> !q[W-1]);
  assert_shl_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && shl && !shr) |=> !q[0]);
  assert_load_first_R4: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(d));
endmodule

// File: rtl/dp_count.sv
module dp_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic [W-1:0] delta,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= d;
    else if (en)  q <= q + delta;
  end

  assert_step_R6_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld && en) |=> q == W'($past(q) + $past(delta)));
  assert_count_load_R4: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(d));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_port,
  output logic [W-1:0] out_port,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [3:0]   fetch_nib,
  output logic         zero_o,
  input  logic [1:0]   alu_op,
  input  logic         alu_bsel,
  input  logic         acc_ld,
  input  logic [1:0]   acc_sel,
  input  logic         acc_shr,
  input  logic         acc_shl,
  input  logic         md_ld,
  input  logic         md_sel,
  input  logic         cnt_ld,
  input  logic         cnt_sel,
  input  logic         cnt_dec,
  input  logic         sr_ld,
  input  logic         ip_ld,
  input  logic         ip_sel,
  input  logic         ip_inc,
  input  logic         ip_by2,
  input  logic         z_ld,
  input  logic         z_clr,
  input  logic         z_set,
  input  logic         addr_sel
);
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] TWO     = W'(2);
  localparam logic [W-1:0] MINUS1  = '1;

  logic [W-1:0] acc_q, md_q, cnt_q, sr_q, ip_q;
  logic         z_q;
  logic [W-1:0] alu_b, alu_y, acc_d, cnt_d, ip_d;

  // shared operator
  assign alu_b = alu_bsel ? mem_rdata : md_q;

  dp_alu #(.W(W)) u_alu (
    .a(acc_q), .b(alu_b), .op(alu_op_t'(alu_op)), .y(alu_y)
  );

  // accumulator source selector
  always_comb begin
    unique case (acc_src_t'(acc_sel))
      ACC_FROM_IN:  acc_d = in_port;
      ACC_FROM_ALU: acc_d = alu_y;
      ACC_FROM_MEM: acc_d = mem_rdata;
      default:      acc_d = cnt_q;
    endcase
  end

  dp_acc #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .ld(acc_ld), .d(acc_d),
    .shr(acc_shr), .shl(acc_shl), .q(acc_q)
  );

  assign cnt_d = cnt_sel ? acc_q : mem_rdata;

  dp_count #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_ld), .d(cnt_d),
    .en(cnt_dec), .delta(MINUS1), .q(cnt_q)
  );

  assign ip_d = ip_sel ? sr_q : mem_rdata;

  dp_count #(.W(W)) u_ip (
    .clk(clk), .rst(rst), .ld(ip_ld), .d(ip_d),
    .en(ip_inc), .delta(ip_by2 ? TWO : ONE), .q(ip_q)
  );

  // plain registers and flag
  always_ff @(posedge clk) begin
    if (rst) begin
      md_q <= '0;
      sr_q <= '0;
      z_q  <= 1'b0;
    end else begin
      if (md_ld) md_q <= md_sel ? acc_q : mem_rdata;
      if (sr_ld) sr_q <= ip_q + TWO;
      if (z_ld)       z_q <= (alu_y == '0);
      else if (z_clr) z_q <= 1'b0;
      else if (z_set) z_q <= 1'b1;
    end
  end

  assign out_port  = acc_q;
  assign mem_addr  = addr_sel ? md_q : ip_q;
  assign fetch_nib = mem_rdata[3:0];
  assign zero_o    = z_q;

  assert_sr_link_R8: assert property (@(posedge clk) disable iff (rst)
    sr_ld |=> sr_q == W'($past(ip_q) + TWO));
  assert_zset_R9: assert property (@(posedge clk) disable iff (rst)
    (!z_ld && !z_clr && z_set) |=> zero_o);
  assert_zclr_R9: assert property (@(posedge clk) disable iff (rst)
    (!z_ld && z_clr) |=> !zero_o);
  assert_zhold_R9: assert property (@(posedge clk) disable iff (rst)
    (!z_ld && !z_clr && !z_set) |=> $stable(zero_o));
  assert_nib_R10: assert property (@(posedge clk) fetch_nib == mem_rdata[3:0]);
endmodule

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_port = '0, mem_rdata = '0;
  logic [1:0] alu_op = '0, acc_sel = '0;
  logic alu_bsel = 0, acc_ld = 0, acc_shr = 0, acc_shl = 0, md_ld = 0, md_sel = 0;
  logic cnt_ld = 0, cnt_sel = 0, cnt_dec = 0, sr_ld = 0, ip_ld = 0, ip_sel = 0;
  logic ip_inc = 0, ip_by2 = 0, z_ld = 0, z_clr = 0, z_set = 0, addr_sel = 0;
  logic [7:0] out_port, mem_addr;
  logic [3:0] fetch_nib;
  logic zero_o;

  int nchk = 0, nerr = 0;
  logic [7:0] m_acc = 0, m_md = 0, m_cnt = 0, m_sr = 0, m_ip = 0;
  logic m_z = 0;
  string      rq[$];
  logic [16:0] vq[$];

  always #2.5 clk = ~clk;

  acc_datapath #(.W(8)) u0 (
    .clk(clk), .rst(rst), .in_port(in_port), .out_port(out_port),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .fetch_nib(fetch_nib),
    .zero_o(zero_o), .alu_op(alu_op), .alu_bsel(alu_bsel), .acc_ld(acc_ld),
    .acc_sel(acc_sel), .acc_shr(acc_shr), .acc_shl(acc_shl), .md_ld(md_ld),
    .md_sel(md_sel), .cnt_ld(cnt_ld), .cnt_sel(cnt_sel), .cnt_dec(cnt_dec),
    .sr_ld(sr_ld), .ip_ld(ip_ld), .ip_sel(ip_sel), .ip_inc(ip_inc),
    .ip_by2(ip_by2), .z_ld(z_ld), .z_clr(z_clr), .z_set(z_set),
    .addr_sel(addr_sel)
  );

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: computes expected state from the requirements, pushes it
  task automatic cyc(string req);
    logic [7:0] b, y, n_acc, n_md, n_cnt, n_sr, n_ip;
    logic n_z;
    b = alu_bsel ? mem_rdata : m_md;
    case (alu_op)
      2'd0: y = m_acc + b;
      2'd1: y = m_acc - b;
      2'd2: y = m_acc & b;
      default: y = m_acc | b;
    endcase
    if (acc_ld) n_acc = (acc_sel == 0) ? in_port : (acc_sel == 1) ? y :
                        (acc_sel == 2) ? mem_rdata : m_cnt;
    else if (acc_shr && !acc_shl) n_acc = m_acc >> 1;
    else if (acc_shl && !acc_shr) n_acc = m_acc << 1;
    else n_acc = m_acc;
    n_md  = md_ld ? (md_sel ? m_acc : mem_rdata) : m_md;
    n_cnt = cnt_ld ? (cnt_sel ? m_acc : mem_rdata) : cnt_dec ? m_cnt - 8'd1 : m_cnt;
    n_sr  = sr_ld ? m_ip + 8'd2 : m_sr;
    n_ip  = ip_ld ? (ip_sel ? m_sr : mem_rdata) :
            ip_inc ? m_ip + (ip_by2 ? 8'd2 : 8'd1) : m_ip;
    n_z   = z_ld ? (y == 0) : z_clr ? 1'b0 : z_set ? 1'b1 : m_z;
    @(posedge clk);
    #1;
    m_acc = n_acc; m_md = n_md; m_cnt = n_cnt; m_sr = n_sr; m_ip = n_ip; m_z = n_z;
    rq.push_back(req);
    vq.push_back({m_acc, m_z, addr_sel ? m_md : m_ip});
    #2;
    {acc_ld, acc_shr, acc_shl, md_ld, cnt_ld, cnt_dec, sr_ld, ip_ld, ip_inc} = '0;
    {z_ld, z_clr, z_set} = '0;
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (vq.size() > 0) begin
        string r;
        logic [16:0] v;
        r = rq.pop_front();
        v = vq.pop_front();
        chk(r, "out_port(R11)", out_port, v[16:9]);
        chk(r, "zero_o", zero_o, v[8]);
        chk(r, "mem_addr", mem_addr, v[7:0]);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    chk("R1", "acc", out_port, 0);
    chk("R1", "zero", zero_o, 0);
    chk("R1", "ip", mem_addr, 0);
    addr_sel = 1; #0.1;
    chk("R1", "md", mem_addr, 0);
    addr_sel = 0;

    in_port = 8'h5A; acc_ld = 1; acc_sel = 0; cyc("R5 in_port");
    mem_rdata = 8'h33; md_ld = 1; md_sel = 0; addr_sel = 1; cyc("R5 md<-mem R10");
    acc_ld = 1; acc_sel = 1; alu_op = 0; alu_bsel = 0; z_ld = 1; cyc("R2 add");
    mem_rdata = 8'h8D; acc_ld = 1; acc_sel = 1; alu_op = 1; alu_bsel = 1; z_ld = 1;
    cyc("R2 sub to zero R9");
    in_port = 8'h81; acc_ld = 1; acc_sel = 0; cyc("R5 in_port");
    mem_rdata = 8'h0F; acc_ld = 1; acc_sel = 1; alu_op = 2; alu_bsel = 1; z_ld = 1;
    cyc("R2 and R9");
    acc_ld = 1; acc_sel = 1; alu_op = 3; alu_bsel = 0; cyc("R2 or");
    acc_shr = 1; cyc("R3 shr");
    acc_shl = 1; cyc("R3 shl");
    acc_shr = 1; acc_shl = 1; cyc("R3 both hold");
    mem_rdata = 8'h81; acc_ld = 1; acc_sel = 2; cyc("R5 acc<-mem");
    acc_shl = 1; cyc("R3 shl fill");
    mem_rdata = 8'h81; acc_ld = 1; acc_sel = 2; cyc("R5 acc<-mem");
    acc_shr = 1; cyc("R3 shr fill");
    in_port = 8'hC3; acc_ld = 1; acc_sel = 0; acc_shr = 1; cyc("R4 acc load wins");
    md_ld = 1; md_sel = 1; cyc("R5 md<-acc R10");

    addr_sel = 0;
    mem_rdata = 8'h01; cnt_ld = 1; cnt_sel = 0; cyc("R5 cnt<-mem");
    cnt_dec = 1; cyc("R6 dec");
    cnt_dec = 1; cyc("R6 dec wrap");
    acc_ld = 1; acc_sel = 3; cyc("R6 cnt to acc");
    in_port = 8'h20; acc_ld = 1; acc_sel = 0; cyc("R5 in_port");
    cnt_ld = 1; cnt_sel = 1; cnt_dec = 1; cyc("R4 cnt load wins");
    acc_ld = 1; acc_sel = 3; cyc("R4 cnt to acc");

    ip_inc = 1; cyc("R7 inc1");
    ip_inc = 1; ip_by2 = 1; cyc("R7 inc2");
    mem_rdata = 8'hFE; ip_ld = 1; ip_sel = 0; cyc("R8 ip<-mem");
    ip_inc = 1; ip_by2 = 1; cyc("R7 wrap");
    mem_rdata = 8'h10; ip_ld = 1; ip_sel = 0; ip_inc = 1; cyc("R4 ip load wins");
    sr_ld = 1; ip_inc = 1; ip_by2 = 0; cyc("R8 sr<-ip+2");
    mem_rdata = 8'h40; ip_ld = 1; ip_sel = 0; cyc("R8 ip<-mem");
    ip_ld = 1; ip_sel = 1; cyc("R8 ip<-sr");

    z_set = 1; cyc("R9 preset");
    z_clr = 1; cyc("R9 clear");
    z_set = 1; z_clr = 1; cyc("R9 clear over preset");
    z_set = 1; cyc("R9 preset");
    alu_op = 3; alu_bsel = 0; z_ld = 1; z_set = 1; cyc("R4 z load wins");

    mem_rdata = 8'hA7; #0.1;
    chk("R10", "fetch_nib", fetch_nib, 4'h7);
    mem_rdata = 8'h3C; #0.1;
    chk("R10", "fetch_nib", fetch_nib, 4'hC);

    repeat (2) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule